// File: doc/BRIEF.md
# Monitor Register Access Trap Resolver

This block decides what happens when software at a given privilege level (0 to 3) reads or writes a monitor control register through the coprocessor path. It takes the access direction, the current level, a description of which higher levels are implemented or enabled, and a set of trap-control bits. From these it produces one of five outcomes: allow, undefined, trap to level 1, trap to level 2 or trap to level 3. It also produces the syndrome code that goes with a trap. The register storage and the exception entry that follows a trap sit outside this block.

The outcome is not a plain privilege comparison. Each level, and each access direction, has its own fixed order of checks, and the first check that matches wins. All higher levels are taken to run in 64-bit state, so every trap uses a single syndrome code.

Requests enter on a valid/ready handshake, and the decision leaves on a second valid/ready handshake. The output is a single register stage. A new request is accepted when that register is empty or is being drained in the same cycle (`req_ready = !res_valid || res_ready`). When the consumer holds `res_ready` low, the stored result stays put and no new request is taken. The control inputs travel with the request and are sampled only in the cycle of acceptance.

Top module: `mon_access_trap_top`

## Requirements
- R1: During and right after reset, `res_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge (`req_valid && req_ready`) gives `res_valid=1` with its outcome after that same edge. While `res_valid && !res_ready`, `res_code` and `res_syndrome` hold steady and `req_ready` is 0.
- R3: `res_code` encodes allow=0, undefined=1, trap-to-1=2, trap-to-2=3, trap-to-3=4. No other value appears while `res_valid` is 1.
- R4: A read at level 3 is always allowed.
- R5: A read at level 2 checks three things in order. First, if level 3 is present and both `mon3_trap` and `l3_undef_prio` are set, the result is undefined. Next, if level 3 is present and `mon3_trap` is set, the result is trap-to-3. Otherwise the read is allowed.
- R6: A read at level 1 checks, in order: the level-3 undefined-priority case; `hyp_reg_trap` (trap-to-2); `hyp_mon_trap` (trap-to-2); the level-3 `mon3_trap` (trap-to-3). If none matches, the read is allowed.
- R7: A read at level 0 checks the level-3 undefined-priority case first. Right after it comes a clear `user_en`, which traps to level 2 when `host_route` is set and level 2 is enabled, and to level 1 otherwise.
- R8: After the `user_en` check, a level-0 read traps to level 2 in three cases, taken in order. The first is `hyp_reg_trap`, which is skipped when `host_route` is set. The second is `hyp_mon_trap`. The third is `fgt_trap`, which needs `fgt_allowed` and is skipped when `host_route` is set. Only after these comes the level-3 `mon3_trap` (trap-to-3).
- R9: A write at level 1 with level 2 enabled and `hyp_reg_trap` set traps to level 2. Otherwise a write is allowed only when `req_level` equals the highest level: 3 if `l3_present`, else 2 if `l2_enabled`, else 1. Any other write is undefined.
- R10: `res_syndrome` is 0x03 for the three trap outcomes and 0x00 for allow and undefined.
- R11: Checks that route to level 2 are skipped when `l2_enabled` is 0. Checks that use `mon3_trap` are skipped when `l3_present` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Current privilege level |
| l2_enabled | input | 1 | Level 2 implemented and enabled |
| l3_present | input | 1 | Level 3 implemented |
| user_en | input | 1 | Level-0 access enable |
| host_route | input | 1 | Host-mode routing of level-0 traps |
| hyp_reg_trap | input | 1 | Level-2 trap for this register |
| hyp_mon_trap | input | 1 | Level-2 monitor-access trap |
| mon3_trap | input | 1 | Level-3 monitor-access trap |
| fgt_allowed | input | 1 | Fine-grained trapping present and enabled by level 3 |
| fgt_trap | input | 1 | Fine-grained trap bit for this register |
| l3_undef_prio | input | 1 | Level-3 trap becomes undefined with top priority |
| res_valid | output | 1 | Decision present |
| res_ready | input | 1 | Consumer takes the decision |
| res_code | output | 3 | Outcome code |
| res_syndrome | output | 6 | Syndrome code for traps |

## Verification
Each decision appears exactly one clock edge after its request is accepted. The bench drives a request at a falling edge and pushes the expected outcome into a queue at that moment. A monitor samples at every falling edge and pops one entry whenever `res_valid && res_ready`, which lines each result up with its request one edge later. For the back-pressure check, `res_ready` is changed just after a rising edge. The held result and `req_ready` are then sampled on three falling edges before release.

// File: rtl/mon_trap_pkg.sv
package mon_trap_pkg;

  typedef enum logic [2:0] {
    OUT_ALLOW = 3'd0,
    OUT_UNDEF = 3'd1,
    OUT_TRAP1 = 3'd2,
    OUT_TRAP2 = 3'd3,
    OUT_TRAP3 = 3'd4
  } outcome_e;

  typedef struct packed {
    logic l2_en;
    logic l3_pres;
    logic user_en;
    logic host;
    logic hyp_reg;
    logic hyp_mon;
    logic mon3;
    logic fgt_ok;
    logic fgt;
    logic undef_prio;
  } trap_ctl_t;

endpackage

// File: rtl/mon_read_chain.sv
module mon_read_chain
  import mon_trap_pkg::*;
(
  input  logic [1:0] level,
  input  trap_ctl_t  ctl,
  output outcome_e   outcome
);

  logic prio_undef, hyp_reg_hit, hyp_mon_hit, mon3_hit, fgt_hit;

  always_comb begin
    prio_undef  = ctl.l3_pres && ctl.mon3 && ctl.undef_prio;
    hyp_reg_hit = ctl.l2_en && ctl.hyp_reg;
    hyp_mon_hit = ctl.l2_en && ctl.hyp_mon;
    mon3_hit    = ctl.l3_pres && ctl.mon3;
    fgt_hit     = ctl.l2_en && !ctl.host && ctl.fgt_ok && ctl.fgt;
  end

  always_comb begin
    outcome = OUT_ALLOW;
    unique case (level)
      2'd3: outcome = OUT_ALLOW;
      2'd2: begin
        if (prio_undef)    outcome = OUT_UNDEF;
        else if (mon3_hit) outcome = OUT_TRAP3;
        else               outcome = OUT_ALLOW;
      end
      2'd1: begin
        if (prio_undef)       outcome = OUT_UNDEF;
        else if (hyp_reg_hit) outcome = OUT_TRAP2;
        else if (hyp_mon_hit) outcome = OUT_TRAP2;
        else if (mon3_hit)    outcome = OUT_TRAP3;
        else                  outcome = OUT_ALLOW;
      end
      default: begin
        if (prio_undef)
          outcome = OUT_UNDEF;
        else if (!ctl.user_en)
          outcome = (ctl.l2_en && ctl.host) ? OUT_TRAP2 : OUT_TRAP1;
        else if (hyp_reg_hit && !ctl.host)
          outcome = OUT_TRAP2;
        else if (hyp_mon_hit)
          outcome = OUT_TRAP2;
        else if (fgt_hit)
          outcome = OUT_TRAP2;
        else if (mon3_hit)
          outcome = OUT_TRAP3;
        else
          outcome = OUT_ALLOW;
      end
    endcase
  end

endmodule

// File: rtl/mon_write_check.sv
module mon_write_check
  import mon_trap_pkg::*;
(
  input  logic [1:0] level,
  input  trap_ctl_t  ctl,
  output outcome_e   outcome
);

  logic [1:0] top_level;

  always_comb begin
    if (ctl.l3_pres)    top_level = 2'd3;
    else if (ctl.l2_en) top_level = 2'd2;
    else                top_level = 2'd1;
  end

  always_comb begin
    if (level == 2'd1 && ctl.l2_en && ctl.hyp_reg) outcome = OUT_TRAP2;
    else if (level == top_level)                   outcome = OUT_ALLOW;
    else                                           outcome = OUT_UNDEF;
  end

endmodule

// File: rtl/mon_access_trap_top.sv
module mon_access_trap_top
  import mon_trap_pkg::*;
#(
  parameter int unsigned SYN_W    = 6,
  parameter int unsigned TRAP_SYN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_level,
  input  logic             l2_enabled,
  input  logic             l3_present,
  input  logic             user_en,
  input  logic             host_route,
  input  logic             hyp_reg_trap,
  input  logic             hyp_mon_trap,
  input  logic             mon3_trap,
  input  logic             fgt_allowed,
  input  logic             fgt_trap,
  input  logic             l3_undef_prio,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [2:0]       res_code,
  output logic [SYN_W-1:0] res_syndrome
);

  localparam logic [SYN_W-1:0] SYN_TRAP = SYN_W'(TRAP_SYN);
  localparam logic [SYN_W-1:0] SYN_NONE = '0;

  trap_ctl_t ctl;
  outcome_e  rd_out, wr_out, sel_out;
  logic      take;

  assign ctl = '{l2_en: l2_enabled, l3_pres: l3_present, user_en: user_en,
                 host: host_route, hyp_reg: hyp_reg_trap, hyp_mon: hyp_mon_trap,
                 mon3: mon3_trap, fgt_ok: fgt_allowed, fgt: fgt_trap,
                 undef_prio: l3_undef_prio};

  mon_read_chain  u_rd (.level(req_level), .ctl(ctl), .outcome(rd_out));
  mon_write_check u_wr (.level(req_level), .ctl(ctl), .outcome(wr_out));

  assign sel_out   = req_write ? wr_out : rd_out;
  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_code     <= 3'd0;
      res_syndrome <= SYN_NONE;
    end else begin
      if (take) begin
        res_valid    <= 1'b1;
        res_code     <= sel_out;
        res_syndrome <= (sel_out == OUT_ALLOW || sel_out == OUT_UNDEF) ? SYN_NONE : SYN_TRAP;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_syndrome))); // R2

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code <= 3'd4)); // R3

  AST_TOP_READ_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && req_level == 2'd3) |=> (res_valid && res_code == 3'd0)); // R4

  AST_USER_WRITE_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && req_level == 2'd0) |=> (res_code == 3'd1)); // R9

  AST_SYNDROME_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_code >= 3'd2) == (res_syndrome == SYN_TRAP))); // R10

endmodule

// File: tb/mon_access_trap_top_tb_top.sv
module mon_access_trap_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, res_ready = 1'b1;
  logic [1:0] req_level = 2'd0;
  logic [9:0] c = '0;
  logic req_ready, res_valid;
  logic [2:0] res_code;
  logic [5:0] res_syndrome;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { logic [2:0] code; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  mon_access_trap_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_level(req_level),
    .l2_enabled(c[9]), .l3_present(c[8]), .user_en(c[7]), .host_route(c[6]),
    .hyp_reg_trap(c[5]), .hyp_mon_trap(c[4]), .mon3_trap(c[3]),
    .fgt_allowed(c[2]), .fgt_trap(c[1]), .l3_undef_prio(c[0]),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_syndrome(res_syndrome));

  // bit map of c: 9 l2, 8 l3, 7 user_en, 6 host, 5 hyp_reg, 4 hyp_mon,
  // 3 mon3, 2 fgt_allowed, 1 fgt, 0 undef_prio
  function automatic logic [2:0] model(bit wr, bit [1:0] lv, bit [9:0] k);
    bit l2 = k[9], l3 = k[8], prio = k[8] && k[3] && k[0];
    bit [1:0] hi;
    if (wr) begin
      if (lv == 1 && l2 && k[5]) return 3;
      hi = l3 ? 2'd3 : (l2 ? 2'd2 : 2'd1);
      return (lv == hi) ? 3'd0 : 3'd1;
    end
    case (lv)
      2'd3: return 0;
      2'd2: begin
        if (prio) return 1;
        if (l3 && k[3]) return 4;
        return 0;
      end
      2'd1: begin
        if (prio) return 1;
        if (l2 && k[5]) return 3;
        if (l2 && k[4]) return 3;
        if (l3 && k[3]) return 4;
        return 0;
      end
      default: begin
        if (prio) return 1;
        if (!k[7]) return (l2 && k[6]) ? 3'd3 : 3'd2;
        if (l2 && !k[6] && k[5]) return 3;
        if (l2 && k[4]) return 3;
        if (l2 && !k[6] && k[2] && k[1]) return 3;
        if (l3 && k[3]) return 4;
        return 0;
      end
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive_exp(bit wr, bit [1:0] lv, bit [9:0] k, logic [2:0] e, string tag);
    exp_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_level = lv; c = k;
    it.code = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drive(bit wr, bit [1:0] lv, bit [9:0] k, string tag);
    drive_exp(wr, lv, k, model(wr, lv, k), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      exp_t it;
      if (q.size() == 0) begin
        check(0, "R2", "unexpected result", res_code, -1);
      end else begin
        it = q.pop_front();
        check(res_code == it.code, it.tag, "code", res_code, it.code);
        check(res_syndrome == ((it.code >= 2) ? 6'd3 : 6'd0), "R10", "syndrome",
              res_syndrome, (it.code >= 2) ? 3 : 0);
        check(res_code <= 3'd4, "R3", "code range", res_code, 4);
      end
    end
  end

  initial begin : watchdog
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [2:0] held;
    repeat (3) @(negedge clk);
    check(res_valid == 0, "R1", "res_valid in reset", res_valid, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(res_valid == 0 && req_ready == 1, "R1", "after reset", {res_valid, req_ready}, 1);

    // directed cases with hand-derived outcomes
    drive_exp(0, 3, 10'b11_0011_1111, 3'd0, "R4");
    drive_exp(0, 2, 10'b11_1000_1001, 3'd1, "R5");
    drive_exp(0, 2, 10'b11_1000_1000, 3'd4, "R5");
    drive_exp(0, 1, 10'b11_1011_1000, 3'd3, "R6");
    drive_exp(0, 1, 10'b11_1000_1000, 3'd4, "R6");
    drive_exp(0, 0, 10'b11_0100_0000, 3'd3, "R7");
    drive_exp(0, 0, 10'b11_0000_0000, 3'd2, "R7");
    drive_exp(0, 0, 10'b01_0100_0000, 3'd2, "R7");
    drive_exp(0, 0, 10'b10_1000_0110, 3'd3, "R8");
    drive_exp(0, 0, 10'b10_1100_0110, 3'd0, "R8");
    drive_exp(0, 0, 10'b11_1110_1000, 3'd4, "R8");
    drive_exp(0, 0, 10'b11_1001_1000, 3'd3, "R8");
    drive_exp(1, 1, 10'b10_0010_0000, 3'd3, "R9");
    drive_exp(1, 2, 10'b10_0000_0000, 3'd0, "R9");
    drive_exp(1, 2, 10'b11_0000_0000, 3'd1, "R9");
    drive_exp(1, 1, 10'b00_0000_0000, 3'd0, "R9");
    drive_exp(0, 1, 10'b00_1011_1000, 3'd0, "R11");
    drive_exp(0, 2, 10'b10_0000_1001, 3'd0, "R11");
    drive_exp(0, 0, 10'b00_1111_0110, 3'd0, "R11");
    idle();

    // exhaustive sweep against the requirement model
    for (int w = 0; w < 2; w++)
      for (int lv = 0; lv < 4; lv++)
        for (int k = 0; k < 1024; k++)
          drive(w[0], lv[1:0], k[9:0],
                w ? "R9" : (lv == 3 ? "R4" : lv == 2 ? "R5" : lv == 1 ? "R6" : "R8"));
    idle();
    repeat (2) @(negedge clk);

    // back-pressure
    @(posedge clk); #1 res_ready = 0;
    drive_exp(0, 1, 10'b11_1000_1000, 3'd4, "R2");
    idle();
    held = res_code;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(res_valid == 1, "R2", "held valid", res_valid, 1);
      check(req_ready == 0, "R2", "ready low on stall", req_ready, 0);
      check(res_code == held && held == 3'd4, "R2", "held code", res_code, 4);
    end
    @(posedge clk); #1 res_ready = 1;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "queue drained", q.size(), 0);
    check(res_valid == 0, "R2", "valid drops", res_valid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule